// File: doc/BRIEF.md
# Programmable Partial-Flag Offset Registers

This block stores the two thresholds behind a FIFO's almost-empty and almost-full indications and produces both flags by comparing the current fill level against them. The FIFO storage, its pointers and its occupancy counter are outside the block. The surrounding FIFO supplies the current occupancy and the configured depth, and the block returns the two active-low partial flags one clock later.

A load-mode pin is sampled while master reset is held. It selects a default threshold for both registers. It also fixes the way the registers can be changed until the next master reset. In parallel mode a write strobe transfers a data bus into the registers, alternating between them. In serial mode the same write strobe shifts one bit per clock into a shift chain that spans both registers. Read strobes return the registers over a parallel output bus in either mode.

A partial reset restarts the access sequence and the flags. It keeps the stored thresholds and the chosen loading method. Both resets are sampled on the rising clock edge. Master reset takes priority over partial reset.

Top module: `pflag_offsets`

## Requirements
- R1: With `mode_sel` low during master reset, both offsets become 127 and loading is parallel; `rd_data` clears to 0.
- R2: With `mode_sel` high during master reset, both offsets become 1023 and loading is serial; in serial mode `pdata` never reaches the offsets.
- R3: In parallel mode, each write strobe (`ld_stb`=1, `ld_wr`=1) stores `pdata`. The first store after a reset goes to the empty offset, the next to the full offset, and then the order wraps.
- R4: In serial mode, each clock with a write strobe shifts in `ser_bit`, least significant bit first. The bits fill the empty offset (bits 0..OFS_W-1) and then the full offset. Bits after the first 2*OFS_W are ignored.
- R5: A read strobe (`ld_stb`=1, `ld_wr`=0) places one offset on `rd_data` after the next clock, in either mode. Reads share the write order: empty offset, full offset, wrap.
- R6: While `prst_n` is low, the offsets and the loading method do not change. Partial reset returns the access order to the empty offset, restarts the serial bit count and clears `rd_data`.
- R7: Under either reset, `ae_n` is 0 and `af_n` is 1.
- R8: One clock after occupancy `occ` is presented, `ae_n` is 0 exactly when `occ` <= the empty offset.
- R9: One clock after `occ` is presented, `af_n` is 0 exactly when `occ` + full offset >= `depth`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, sampled on clock |
| prst_n | input | 1 | Partial reset, active low, sampled on clock |
| mode_sel | input | 1 | Load-mode select, sampled during master reset (0 parallel, 1 serial) |
| ld_stb | input | 1 | Register access strobe |
| ld_wr | input | 1 | Access direction: 1 write/shift, 0 read |
| pdata | input | OFS_W | Parallel write data |
| ser_bit | input | 1 | Serial load bit |
| occ | input | OCC_W | Current FIFO occupancy |
| depth | input | OCC_W | FIFO depth |
| rd_data | output | OFS_W | Parallel read-back data |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
The assertions assume that `mode_sel` is settled before the clock edges that sample master reset. They also assume that `occ` and `depth` are changed only away from the clock edge, and that `occ` never exceeds `depth`. The bench changes every input on the falling edge and holds `mode_sel` for the whole master-reset window. All of its occupancy values lie between zero and the depth. A master reset always opens a test phase, so the loading method never changes while strobes are active.

// File: rtl/pflag_pkg.sv
package pflag_pkg;
  typedef enum logic {LOAD_PAR = 1'b0, LOAD_SER = 1'b1} load_mode_e;

  // default threshold picked by the load mode at master reset
  function automatic int unsigned dflt_ofs(load_mode_e m);
    return (m == LOAD_SER) ? 32'd1023 : 32'd127;
  endfunction

  // almost-empty condition: fill level at or below the empty offset
  function automatic logic near_empty(int unsigned occ, int unsigned ofs);
    return occ <= ofs;
  endfunction

  // almost-full condition: free space at or below the full offset
  function automatic logic near_full(int unsigned occ, int unsigned depth,
                                     int unsigned ofs);
    return (occ + ofs) >= depth;
  endfunction
endpackage

// File: rtl/pflag_ofs_regs.sv
module pflag_ofs_regs
  import pflag_pkg::*;
#(
  parameter int OFS_W = 14
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             mode_sel,
  input  logic             ld_stb,
  input  logic             ld_wr,
  input  logic [OFS_W-1:0] pdata,
  input  logic             ser_bit,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic [OFS_W-1:0] rd_data
);
  localparam int TOT    = 2 * OFS_W;
  localparam int SCNT_W = $clog2(TOT + 1);

  logic              ser_mode;
  logic              sel_full;
  logic [SCNT_W-1:0] scnt;

  // named access events
  logic par_wr, ser_wr, rd_go, ser_done;
  assign ser_done = (scnt == SCNT_W'(TOT));
  assign par_wr   = prst_n && ld_stb && ld_wr && !ser_mode;
  assign ser_wr   = prst_n && ld_stb && ld_wr && ser_mode && !ser_done;
  assign rd_go    = prst_n && ld_stb && !ld_wr;

  // offsets and loading method: touched by master reset only, never by partial
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ser_mode <= mode_sel;
      ae_ofs   <= OFS_W'(dflt_ofs(load_mode_e'(mode_sel)));
      af_ofs   <= OFS_W'(dflt_ofs(load_mode_e'(mode_sel)));
    end else if (par_wr) begin
      if (sel_full) af_ofs <= pdata;
      else          ae_ofs <= pdata;
    end else if (ser_wr) begin
      for (int i = 0; i < OFS_W; i++) begin
        if (scnt == SCNT_W'(i))         ae_ofs[i] <= ser_bit;
        if (scnt == SCNT_W'(i + OFS_W)) af_ofs[i] <= ser_bit;
      end
    end
  end

  // access order, serial count and read register: cleared by both resets
  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      sel_full <= 1'b0;
      scnt     <= '0;
      rd_data  <= '0;
    end else begin
      if (par_wr || rd_go) sel_full <= !sel_full;
      if (rd_go)           rd_data  <= sel_full ? af_ofs : ae_ofs;
      if (ser_wr)          scnt     <= scnt + 1'b1;
    end
  end

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    1'b1 |=> $stable(ser_mode));

  p_prst_keep_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> $stable(ae_ofs) && $stable(af_ofs));

  p_par_blocked_r2: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_mode && !(ld_stb && ld_wr)) |=> $stable(ae_ofs) && $stable(af_ofs));

  p_ser_limit_r4: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_done && prst_n) |=> $stable(ae_ofs) && $stable(af_ofs));

  p_par_idle_r3: assert property (@(posedge clk) disable iff (!mrst_n)
    (!ser_mode && !(ld_stb && ld_wr)) |=> $stable(ae_ofs) && $stable(af_ofs));
endmodule

// File: rtl/pflag_cmp.sv
module pflag_cmp
  import pflag_pkg::*;
#(
  parameter int OFS_W = 14,
  parameter int OCC_W = 15
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] depth,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  output logic             ae_n,
  output logic             af_n
);
  logic hit_empty, hit_full;
  assign hit_empty = near_empty(int'(occ), int'(ae_ofs));
  assign hit_full  = near_full(int'(occ), int'(depth), int'(af_ofs));

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      ae_n <= 1'b0;
      af_n <= 1'b1;
    end else begin
      ae_n <= !hit_empty;
      af_n <= !hit_full;
    end
  end

  p_flag_reset_r7: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> !ae_n && af_n);

  p_empty_at_zero_r8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (occ == '0) |=> !ae_n);

  p_full_at_depth_r9: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (occ >= depth) |=> !af_n);
endmodule

// File: rtl/pflag_offsets.sv
module pflag_offsets
  import pflag_pkg::*;
#(
  parameter int OFS_W = 14,
  parameter int OCC_W = OFS_W + 1
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             mode_sel,
  input  logic             ld_stb,
  input  logic             ld_wr,
  input  logic [OFS_W-1:0] pdata,
  input  logic             ser_bit,
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] depth,
  output logic [OFS_W-1:0] rd_data,
  output logic             ae_n,
  output logic             af_n
);
  logic [OFS_W-1:0] ae_ofs, af_ofs;

  pflag_ofs_regs #(.OFS_W(OFS_W)) u_regs (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .ld_stb(ld_stb), .ld_wr(ld_wr), .pdata(pdata), .ser_bit(ser_bit),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_data(rd_data)
  );

  pflag_cmp #(.OFS_W(OFS_W), .OCC_W(OCC_W)) u_cmp (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .occ(occ), .depth(depth),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ae_n(ae_n), .af_n(af_n)
  );

  p_rd_clear_r5: assert property (@(posedge clk)
    (!mrst_n || !prst_n) |=> (rd_data == '0));
endmodule

// File: tb/pflag_offsets_test.sv
module pflag_offsets_test;
  localparam int OFS_W = 14;
  localparam int OCC_W = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
  logic             ld_stb = 1'b0, ld_wr = 1'b0, ser_bit = 1'b0;
  logic [OFS_W-1:0] pdata = '0;
  logic [OCC_W-1:0] occ = '0, depth = '0;
  logic [OFS_W-1:0] rd_data;
  logic             ae_n, af_n;

  int checks = 0;
  int failures = 0;

  pflag_offsets #(.OFS_W(OFS_W), .OCC_W(OCC_W)) uut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .ld_stb(ld_stb), .ld_wr(ld_wr), .pdata(pdata), .ser_bit(ser_bit),
    .occ(occ), .depth(depth), .rd_data(rd_data), .ae_n(ae_n), .af_n(af_n)
  );

  // {occ, depth, expected ae_n, expected af_n} with both offsets at 127
  localparam logic [33:0] VEC [8] = '{
    {16'd0,    16'd1024, 1'b0, 1'b1},
    {16'd127,  16'd1024, 1'b0, 1'b1},
    {16'd128,  16'd1024, 1'b1, 1'b1},
    {16'd896,  16'd1024, 1'b1, 1'b1},
    {16'd897,  16'd1024, 1'b1, 1'b0},
    {16'd1024, 16'd1024, 1'b1, 1'b0},
    {16'd73,   16'd200,  1'b0, 1'b0},
    {16'd72,   16'd200,  1'b0, 1'b1}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_mrst(logic m);
    mrst_n = 1'b0; mode_sel = m; ld_stb = 1'b0;
    repeat (2) @(negedge clk);
    mrst_n = 1'b1;
    check("R7 ae_n after master reset", int'(ae_n), 0);
    check("R7 af_n after master reset", int'(af_n), 1);
    check("R1 rd_data cleared", int'(rd_data), 0);
  endtask

  task automatic do_prst();
    prst_n = 1'b0;
    @(negedge clk);
    prst_n = 1'b1;
    check("R6 ae_n during partial reset", int'(ae_n), 0);
    check("R6 af_n during partial reset", int'(af_n), 1);
  endtask

  task automatic pwrite(int v, logic sb);
    ld_stb = 1'b1; ld_wr = 1'b1; pdata = OFS_W'(v); ser_bit = sb;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic pread(string tag, int exp);
    ld_stb = 1'b1; ld_wr = 1'b0;
    @(negedge clk);
    ld_stb = 1'b0;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic sshift(logic [31:0] v, int n);
    for (int i = 0; i < n; i++) begin
      ld_stb = 1'b1; ld_wr = 1'b1; ser_bit = v[i];
      @(negedge clk);
    end
    ld_stb = 1'b0;
  endtask

  task automatic flags(string tag, int o, int d, int eae, int eaf);
    occ = OCC_W'(o); depth = OCC_W'(d);
    @(negedge clk);
    check({tag, " ae_n"}, int'(ae_n), eae);
    check({tag, " af_n"}, int'(af_n), eaf);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // parallel mode, default 127 thresholds (R1)
    do_mrst(1'b0);
    for (int i = 0; i < 8; i++)
      flags("R8/R9 vector", int'(VEC[i][33:18]), int'(VEC[i][17:2]),
            int'(VEC[i][1]), int'(VEC[i][0]));
    pread("R1 R5 empty default", 127);
    pread("R1 R5 full default", 127);
    // R3 alternating parallel writes
    pwrite(5, 1'b1);
    pwrite(900, 1'b0);
    pread("R3 empty offset", 5);
    pread("R3 full offset", 900);
    flags("R8 occ=5", 5, 2000, 0, 1);
    flags("R8 occ=6", 6, 2000, 1, 1);
    flags("R9 occ=1100", 1100, 2000, 1, 0);
    flags("R9 occ=1099", 1099, 2000, 1, 1);
    pwrite(7, 1'b0);
    pread("R3 wrap read full", 900);
    // R6 partial reset keeps values, restarts order
    do_prst();
    check("R6 rd_data cleared", int'(rd_data), 0);
    pread("R6 empty kept", 7);
    pread("R6 full kept", 900);

    // serial mode, default 1023 (R2)
    do_mrst(1'b1);
    pread("R2 R5 empty default", 1023);
    pread("R2 R5 full default", 1023);
    // R2: write strobe in serial mode takes ser_bit, not pdata
    pwrite(3, 1'b0);
    pread("R2 pdata ignored, empty", 1022);
    pread("R2 full untouched", 1023);
    // R4 full serial load plus extra bits; partial reset restarts count
    do_prst();
    sshift((32'd5 << OFS_W) | 32'd10, 2 * OFS_W);
    sshift(32'hF, 4);
    pread("R4 serial empty offset", 10);
    pread("R4 serial full offset", 5);
    flags("R8 serial occ=10", 10, 100, 0, 1);
    flags("R9 serial occ=95", 95, 100, 1, 0);
    flags("R9 serial occ=94", 94, 100, 1, 1);
    do_prst();
    pread("R6 serial empty kept", 10);
    pread("R6 serial full kept", 5);
    // R6: method kept, count restarted: 14 new bits load empty offset only
    sshift(32'd3, OFS_W);
    pread("R6 R4 reload empty", 3);
    pread("R6 R4 full unchanged", 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule